// File: doc/BRIEF.md
# Energy Pulse Width Limiter

This block turns single-cycle pulse requests from a metering engine into output pulses on two pins, one for real energy and one for reactive energy. Each output pulse is held for a bounded number of timing ticks and separated from the next pulse on the same pin by an idle gap, so that an external counter or optical reader can resolve every pulse.

A programmable interval sets the tick used for timing. With an interval of zero the tick is the incoming sample tick itself, and a request arriving on an idle channel starts its pulse at once. With a nonzero interval the tick fires once every N sample ticks, and requests wait in a small per-channel pending count until a tick boundary lets them out. A width code W caps every pulse at 2W+1 ticks. The all-ones code removes the cap, and a pulse then lasts until a further request is waiting. A single polarity input selects active-low or active-high outputs for both pins.

Top module: `enpulse_limiter`

## Requirements
- R1: During and after reset, with no request seen, both outputs sit at the inactive level (1 when `cfg_active_high` is 0) and nothing is pending.
- R2: With `cfg_interval` = 0 the tick equals `sample_tick`, and a request on an idle channel makes that output active from the clock edge that samples the request.
- R3: With `cfg_interval` = N > 0 the tick fires on every Nth `sample_tick`, and a pulse only begins on a tick.
- R4: With `cfg_width` = W below 255, a pulse ends on the (2W+1)th tick after its start. In queued mode the pulse is therefore exactly (2W+1)·N·(sample period) clocks wide.
- R5: With `cfg_width` = 255 a pulse stays active until a further request is pending, and then ends on the next tick.
- R6: After a pulse ends, the output stays inactive until the next tick. If a request is pending at that tick, the next pulse starts on it, so the gap between back-to-back pulses is exactly one tick.
- R7: Each channel holds at most 4 pending requests. Requests arriving while 4 are pending are discarded and produce no pulse.
- R8: `cfg_active_high` = 0 gives active-low outputs. A value of 1 gives active-high outputs on both pins.
- R9: The two channels share the tick and configuration, but their requests, pending counts and pulses are independent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_tick | input | 1 | One-cycle strobe at the base sample rate |
| req_real | input | 1 | One-cycle pulse request, real-energy channel |
| req_reactive | input | 1 | One-cycle pulse request, reactive-energy channel |
| cfg_width | input | 8 | Width code W; the pulse cap is 2W+1 ticks, 255 removes the cap |
| cfg_interval | input | 8 | Sample ticks per timing tick; 0 selects bypass mode |
| cfg_active_high | input | 1 | Output polarity: 0 active low, 1 active high |
| pulse_real | output | 1 | Real-energy output pulse |
| pulse_reactive | output | 1 | Reactive-energy output pulse |

## Verification
The bench builds the block with its default parameters: 8-bit codes and 4 pending slots per channel. It drives `sample_tick` every fourth clock and uses width codes 0, 1 and 255 with intervals 0, 1 and 2. These settings keep pulses to a few dozen clocks, so a bench of a few thousand cycles can reach bursts that fill the pending count, exact one-tick gaps, the uncapped mode and both polarities. In bypass mode the request is placed at a fixed phase relative to the sample tick, which makes the expected width exact.

// File: rtl/enpulse_pkg.sv
package enpulse_pkg;

    localparam int NUM_CH     = 2;
    localparam int CODE_W     = 8;
    localparam int PEND_DEPTH = 4;
    localparam int PEND_W     = $clog2(PEND_DEPTH + 1);
    localparam int TICKS_W    = CODE_W + 1;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_GAP    = 2'd2
    } chan_state_t;

    // All-ones width code disables the width cap.
    function automatic logic cap_disabled(input logic [CODE_W-1:0] code);
        return &code;
    endfunction

    // Last tick index (0-based) of a capped pulse: 2W.
    function automatic logic [TICKS_W-1:0] last_tick_idx(input logic [CODE_W-1:0] code);
        return {code, 1'b0};
    endfunction

endpackage

// File: rtl/enpulse_tickgen.sv
module enpulse_tickgen
    import enpulse_pkg::*;
#(
    parameter int IW = CODE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sample_tick,
    input  logic [IW-1:0] interval,
    output logic          bypass,
    output logic          ti
);
    logic [IW-1:0] div_cnt;
    logic          wrap;

    assign bypass = (interval == '0);
    assign wrap   = (div_cnt >= interval - IW'(1));
    assign ti     = bypass ? sample_tick : (sample_tick && wrap);

    always_ff @(posedge clk) begin
        if (rst || bypass) begin
            div_cnt <= '0;
        end else if (sample_tick) begin
            div_cnt <= wrap ? '0 : div_cnt + IW'(1);
        end
    end

    // R3: a timing tick can only fall on a sample tick
    assert_tick_on_sample_R3: assert property (@(posedge clk) disable iff (rst)
        ti |-> sample_tick);

    // R3: after a divided tick the divider restarts its count
    assert_div_restart_R3: assert property (@(posedge clk) disable iff (rst)
        (ti && !bypass) |=> (div_cnt == '0));

endmodule

// File: rtl/enpulse_chan.sv
module enpulse_chan
    import enpulse_pkg::*;
#(
    parameter int WW    = CODE_W,
    parameter int DEPTH = PEND_DEPTH
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ti,
    input  logic          bypass,
    input  logic          req,
    input  logic [WW-1:0] width_code,
    output logic          active
);
    localparam int PW = $clog2(DEPTH + 1);
    localparam int CW = WW + 1;

    chan_state_t   state;
    logic [PW-1:0] pend;
    logic [CW-1:0] tick_cnt;
    logic          have_work;
    logic          start;
    logic          uncapped;
    logic          finish;

    assign uncapped  = cap_disabled(width_code);
    assign have_work = (pend != '0) || req;
    assign start     = ((state == ST_IDLE) && have_work && (bypass || ti)) ||
                       ((state == ST_GAP)  && have_work && ti);
    assign finish    = (state == ST_ACTIVE) && ti &&
                       (uncapped ? (pend != '0)
                                 : (tick_cnt >= last_tick_idx(width_code)));
    assign active    = (state == ST_ACTIVE);

    // Pending count: +1 per request, -1 per pulse start, saturating at DEPTH.
    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
        end else if (start && !req) begin
            pend <= pend - PW'(1);
        end else if (!start && req && (pend != PW'(DEPTH))) begin
            pend <= pend + PW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            tick_cnt <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state    <= ST_ACTIVE;
                        tick_cnt <= '0;
                    end
                end
                ST_ACTIVE: begin
                    if (finish) begin
                        state <= ST_GAP;
                    end else if (ti && (tick_cnt != '1)) begin
                        tick_cnt <= tick_cnt + CW'(1);
                    end
                end
                ST_GAP: begin
                    if (ti) begin
                        state    <= start ? ST_ACTIVE : ST_IDLE;
                        tick_cnt <= '0;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R7: pending count never exceeds its depth
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
        pend <= PW'(DEPTH));

    // R2: bypass mode starts an idle channel on the request edge
    assert_bypass_start_R2: assert property (@(posedge clk) disable iff (rst)
        (bypass && (state == ST_IDLE) && req) |=> active);

    // R3: a queued pulse only begins on a tick
    assert_start_on_tick_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(active) |-> $past(ti || bypass));

    // R4: a capped pulse never counts past its last tick
    assert_width_cap_R4: assert property (@(posedge clk) disable iff (rst)
        (active && !uncapped) |-> (tick_cnt <= last_tick_idx(width_code)));

    // R6: the gap holds the output inactive until a tick
    assert_gap_hold_R6: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_GAP) && !ti) |=> !active);

endmodule

// File: rtl/enpulse_limiter.sv
module enpulse_limiter
    import enpulse_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sample_tick,
    input  logic              req_real,
    input  logic              req_reactive,
    input  logic [CODE_W-1:0] cfg_width,
    input  logic [CODE_W-1:0] cfg_interval,
    input  logic              cfg_active_high,
    output logic              pulse_real,
    output logic              pulse_reactive
);
    logic              ti;
    logic              bypass;
    logic [NUM_CH-1:0] req_vec;
    logic [NUM_CH-1:0] act_vec;
    logic [NUM_CH-1:0] pin_vec;

    assign req_vec = {req_reactive, req_real};

    enpulse_tickgen #(.IW(CODE_W)) u_tick (
        .clk         (clk),
        .rst         (rst),
        .sample_tick (sample_tick),
        .interval    (cfg_interval),
        .bypass      (bypass),
        .ti          (ti)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        enpulse_chan #(.WW(CODE_W), .DEPTH(PEND_DEPTH)) u_chan (
            .clk        (clk),
            .rst        (rst),
            .ti         (ti),
            .bypass     (bypass),
            .req        (req_vec[c]),
            .width_code (cfg_width),
            .active     (act_vec[c])
        );
        assign pin_vec[c] = cfg_active_high ? act_vec[c] : ~act_vec[c];
    end

    assign pulse_real     = pin_vec[0];
    assign pulse_reactive = pin_vec[1];

    // R1: the cycle after reset, no channel is active
    assert_reset_idle_R1: assert property (@(posedge clk)
        $past(rst) |-> (act_vec == '0));

endmodule

// File: tb/enpulse_limiter_tb.sv
module enpulse_limiter_tb;

    typedef struct {
        int w;
        int g;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sample_tick = 1'b0;
    logic       req_real = 1'b0;
    logic       req_reactive = 1'b0;
    logic [7:0] cfg_width = 8'd1;
    logic [7:0] cfg_interval = 8'd0;
    logic       cfg_active_high = 1'b0;
    logic       pulse_real;
    logic       pulse_reactive;

    int   cyc = 0;
    int   n_tests = 0;
    int   n_fail = 0;
    exp_t q0[$];
    exp_t q1[$];

    enpulse_limiter u_dut (
        .clk             (clk),
        .rst             (rst),
        .sample_tick     (sample_tick),
        .req_real        (req_real),
        .req_reactive    (req_reactive),
        .cfg_width       (cfg_width),
        .cfg_interval    (cfg_interval),
        .cfg_active_high (cfg_active_high),
        .pulse_real      (pulse_real),
        .pulse_reactive  (pulse_reactive)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        #1 sample_tick <= (((cyc + 1) % 4) == 0);
    end

    task automatic check(input string rq, input int act, input int expv, input string what);
        n_tests++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, expv);
        end
    endtask

    task automatic push_exp(input int ch, input int w, input int g);
        exp_t e;
        e.w = w;
        e.g = g;
        if (ch == 0) q0.push_back(e); else q1.push_back(e);
    endtask

    // Monitor: measures pulse widths and gaps, pops and compares.
    logic [1:0] in_p = '0;
    int         len[2];
    int         gap[2];
    exp_t       cur[2];

    always @(negedge clk) begin
        for (int ch = 0; ch < 2; ch++) begin
            logic pin;
            logic act;
            pin = (ch == 0) ? pulse_real : pulse_reactive;
            act = (pin == cfg_active_high);
            if (rst) begin
                in_p[ch] = 1'b0;
                gap[ch]  = 0;
                len[ch]  = 0;
            end else if (act) begin
                if (!in_p[ch]) begin
                    int qsz;
                    qsz = (ch == 0) ? q0.size() : q1.size();
                    n_tests++;
                    if (qsz == 0) begin
                        n_fail++;
                        $display("FAIL R7 ch%0d unexpected pulse: actual 1 expected 0", ch);
                        cur[ch].w = -1;
                        cur[ch].g = -1;
                    end else begin
                        cur[ch] = (ch == 0) ? q0.pop_front() : q1.pop_front();
                    end
                    if (cur[ch].g >= 0)
                        check("R6", gap[ch], cur[ch].g, $sformatf("ch%0d gap", ch));
                    in_p[ch] = 1'b1;
                    len[ch]  = 1;
                end else begin
                    len[ch]++;
                end
            end else begin
                if (in_p[ch]) begin
                    if (cur[ch].w >= 0)
                        check("R4", len[ch], cur[ch].w, $sformatf("ch%0d width", ch));
                    in_p[ch] = 1'b0;
                    gap[ch]  = 1;
                end else begin
                    gap[ch]++;
                end
            end
        end
    end

    task automatic do_reset(input logic [7:0] w, input logic [7:0] iv, input logic hi);
        @(posedge clk); #1;
        rst = 1'b1;
        cfg_width = w;
        cfg_interval = iv;
        cfg_active_high = hi;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    task automatic req_pulse(input int ch);
        @(posedge clk); #1;
        if (ch == 0) req_real = 1'b1; else req_reactive = 1'b1;
        @(posedge clk); #1;
        req_real = 1'b0;
        req_reactive = 1'b0;
    endtask

    // Bypass request placed so it is sampled one clock after a sample tick.
    task automatic bypass_req(input int ch);
        do begin @(posedge clk); #1; end while ((cyc % 4) != 0);
        if (ch == 0) req_real = 1'b1; else req_reactive = 1'b1;
        @(posedge clk); #1;
        req_real = 1'b0;
        req_reactive = 1'b0;
        @(negedge clk);
        check("R2", int'(((ch == 0) ? pulse_real : pulse_reactive) == cfg_active_high), 1,
              $sformatf("ch%0d active right after request", ch));
    endtask

    task automatic drain(input int n, input string rq);
        repeat (n) @(posedge clk);
        check(rq, q0.size() + q1.size(), 0, "outstanding expected pulses");
    endtask

    initial begin
        // R1: reset levels
        do_reset(8'd1, 8'd0, 1'b0);
        @(negedge clk);
        check("R1", int'(pulse_real), 1, "real idle level");
        check("R1", int'(pulse_reactive), 1, "reactive idle level");

        // R2/R4: bypass, W=1 -> 3+8W = 11 clocks; R9 reactive W=1 too
        push_exp(0, 11, -1);
        bypass_req(0);
        push_exp(1, 11, -1);
        bypass_req(1);
        drain(60, "R2");
        cfg_width = 8'd0;
        push_exp(1, 3, -1);
        bypass_req(1);
        drain(30, "R4");

        // R3/R4/R6/R9: interval 2 -> tick = 8 clocks, W=1 -> 24 clocks, gap 8
        do_reset(8'd1, 8'd2, 1'b0);
        push_exp(0, 24, -1);
        push_exp(0, 24, 8);
        push_exp(0, 24, 8);
        push_exp(1, 24, -1);
        req_pulse(0);
        req_pulse(0);
        req_pulse(1);
        req_pulse(0);
        drain(200, "R3");

        // R7: 6 requests during an active pulse, only 4 stored
        do_reset(8'd0, 8'd2, 1'b0);
        push_exp(0, 8, -1);
        req_pulse(0);
        do @(negedge clk); while (pulse_real != 1'b0);
        for (int i = 0; i < 4; i++) push_exp(0, 8, 8);
        @(posedge clk); #1 req_real = 1'b1;
        repeat (6) @(posedge clk);
        #1 req_real = 1'b0;
        drain(150, "R7");

        // R5: uncapped, interval 1 -> tick = 4 clocks
        do_reset(8'd255, 8'd1, 1'b0);
        push_exp(0, -1, -1);
        req_pulse(0);
        repeat (80) @(posedge clk);
        @(negedge clk);
        check("R5", int'(pulse_real), 0, "uncapped pulse still active");
        push_exp(0, -1, 4);
        req_pulse(0);
        drain(40, "R5");

        // R8: active-high polarity
        do_reset(8'd0, 8'd0, 1'b1);
        @(negedge clk);
        check("R8", int'(pulse_real), 0, "real idle level active-high");
        check("R8", int'(pulse_reactive), 0, "reactive idle level active-high");
        push_exp(0, 3, -1);
        bypass_req(0);
        drain(30, "R8");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(5ns * 100000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule